// File: doc/BRIEF.md
# Prescaled 64-bit Alarm Timer

This block is a 64-bit time base that advances by one step each time its programmable prescaler expires. A 16-bit divider sets how many input clocks make one step, and a direction bit picks counting up or down. The count wraps modulo 2^64 in both directions. While an alarm is armed, the block compares the live count with a 64-bit alarm value. A match raises an alarm, which disarms itself. The alarm can also copy a preset into the counter when auto-reload is on, and it can signal through a sticky level interrupt, a one-clock edge pulse, or both.

Software uses a word-wide write/read port. It never reads the live count directly. Writing any value to a capture trigger copies the count into a snapshot pair, and the two halves of that pair can then be read consistently. A new count is staged in a preset pair and reaches the counter only when a separate load trigger is written. Read data is registered and appears one clock after the address is presented.

Top module: `alarm_timer64`

## Requirements
- R1: The counter moves by one step every N clocks while the run bit (control bit 0) is set, where N is the divider in control bits [31:16], and a divider of 0 or 1 acts as 2. With run cleared the count holds.
- R2: Control bit 1 selects the direction (1 = up, 0 = down). The 64-bit count wraps modulo 2^64, and a carry or borrow crosses between the two 32-bit halves.
- R3: A write of any value to address 1 copies the count held before that clock edge into the snapshot. Address 2 reads the low word of the snapshot and address 3 reads the high word, and the snapshot does not change until the next capture.
- R4: Writes to the preset words (address 6 low, address 7 high) do not change the count. Only a write to address 8 moves the preset into the counter.
- R5: When the arm bit (control bit 3) is set and the count equals the alarm value (address 4 low, address 5 high), an alarm fires and the arm bit clears, and this clearing wins over a control write in the same clock.
- R6: If auto-reload (control bit 2) is set when an alarm fires, the count becomes the preset value on that clock edge.
- R7: An alarm with the level enable (control bit 4) set raises irq_level. irq_level stays high until irq_clr is asserted, and a new alarm wins over a clear in the same clock.
- R8: An alarm with the edge enable (control bit 5) set drives irq_edge high for exactly one clock, one clock after the match.
- R9: A load trigger takes priority over a count step and over an auto-reload in the same clock, so the next count is exactly the preset.
- R10: Synchronous reset clears the count, the snapshot, the alarm value, the preset and every control field, and drives both interrupts and rd_data low.
- R11: rd_data shows, one clock after addr is applied, the register at that address. Address 0 returns the control word with the present arm state, and unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at addr |
| addr | input | 4 | Register address for writes and reads |
| wr_data | input | 32 | Write data |
| irq_clr | input | 1 | Clears the level interrupt |
| rd_data | output | 32 | Registered read data |
| irq_level | output | 1 | Sticky alarm interrupt |
| irq_edge | output | 1 | One-clock alarm pulse |

## Verification
The bench goes after a divider of 0 or 1. A design that took it literally would step every clock or never step. It also tests down-counting through zero and up-counting across the 32-bit boundary, where a missing carry or borrow would leave the high word wrong. A load trigger is placed both on and off a prescaler step: a design with the wrong priority would show the preset plus one. The alarm is checked for self-disarming and for a single edge pulse, since a design that stayed armed would fire again after an auto-reload. Writes to the preset words alone must leave the count unchanged, and a design that loaded early would show the staged value in the next snapshot.

// File: rtl/alarm_timer64_pkg.sv
package alarm_timer64_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL      = 4'd0;
  localparam logic [ADDR_W-1:0] A_SNAP_TRIG = 4'd1;
  localparam logic [ADDR_W-1:0] A_SNAP_LO   = 4'd2;
  localparam logic [ADDR_W-1:0] A_SNAP_HI   = 4'd3;
  localparam logic [ADDR_W-1:0] A_CMP_LO    = 4'd4;
  localparam logic [ADDR_W-1:0] A_CMP_HI    = 4'd5;
  localparam logic [ADDR_W-1:0] A_PRE_LO    = 4'd6;
  localparam logic [ADDR_W-1:0] A_PRE_HI    = 4'd7;
  localparam logic [ADDR_W-1:0] A_LOAD_TRIG = 4'd8;

  localparam int CB_RUN     = 0;
  localparam int CB_UP      = 1;
  localparam int CB_AUTO    = 2;
  localparam int CB_ARM     = 3;
  localparam int CB_LVL     = 4;
  localparam int CB_EDGE    = 5;
  localparam int CB_DIV_LSB = 16;
endpackage

// File: rtl/atm_prescaler.sv
module atm_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] divider,
  output logic             tick
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] n_eff;
  logic [DIV_W-1:0] last_phase;

  always_comb begin
    n_eff      = (divider < MIN_DIV) ? MIN_DIV : divider;
    last_phase = n_eff - DIV_W'(1);
    tick       = run && (phase_q >= last_phase);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) phase_q <= '0;
    else if (tick)   phase_q <= '0;
    else             phase_q <= phase_q + DIV_W'(1);
  end
endmodule

// File: rtl/atm_counter.sv
module atm_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             up,
  input  logic             auto_reload,
  input  logic             armed,
  input  logic             force_load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] alarm_val,
  output logic [CNT_W-1:0] count,
  output logic             fire
);
  assign fire = armed && (count == alarm_val);

  always_ff @(posedge clk) begin
    if (rst)                       count <= '0;
    else if (force_load)           count <= load_val;
    else if (fire && auto_reload)  count <= load_val;
    else if (tick)                 count <= up ? count + CNT_W'(1) : count - CNT_W'(1);
  end
endmodule

// File: rtl/alarm_timer64.sv
module alarm_timer64
  import alarm_timer64_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_level,
  output logic              irq_edge
);
  localparam int CNT_W = 2 * DATA_W;

  logic run_q, up_q, auto_q, arm_q, lvl_en_q, edge_en_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cmp_q, pre_q, snap_q, count;
  logic tick, alarm_fire;
  logic wr_ctrl, wr_snap_trig, wr_load_trig;
  logic [DATA_W-1:0] ctrl_word, rd_next;

  assign wr_ctrl      = wr_en && (addr == A_CTRL);
  assign wr_snap_trig = wr_en && (addr == A_SNAP_TRIG);
  assign wr_load_trig = wr_en && (addr == A_LOAD_TRIG);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; up_q <= 1'b0; auto_q <= 1'b0;
      lvl_en_q <= 1'b0; edge_en_q <= 1'b0; div_q <= '0;
    end else if (wr_ctrl) begin
      run_q     <= wr_data[CB_RUN];
      up_q      <= wr_data[CB_UP];
      auto_q    <= wr_data[CB_AUTO];
      lvl_en_q  <= wr_data[CB_LVL];
      edge_en_q <= wr_data[CB_EDGE];
      div_q     <= wr_data[CB_DIV_LSB +: DIV_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             arm_q <= 1'b0;
    else if (alarm_fire) arm_q <= 1'b0;
    else if (wr_ctrl)    arm_q <= wr_data[CB_ARM];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      pre_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CMP_LO: cmp_q[DATA_W-1:0]      <= wr_data;
        A_CMP_HI: cmp_q[CNT_W-1:DATA_W]  <= wr_data;
        A_PRE_LO: pre_q[DATA_W-1:0]      <= wr_data;
        A_PRE_HI: pre_q[CNT_W-1:DATA_W]  <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               snap_q <= '0;
    else if (wr_snap_trig) snap_q <= count;
  end

  atm_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q),
    .divider (div_q),
    .tick    (tick)
  );

  atm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .up          (up_q),
    .auto_reload (auto_q),
    .armed       (arm_q),
    .force_load  (wr_load_trig),
    .load_val    (pre_q),
    .alarm_val   (cmp_q),
    .count       (count),
    .fire        (alarm_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level <= 1'b0;
      irq_edge  <= 1'b0;
    end else begin
      irq_edge <= alarm_fire && edge_en_q;
      if (alarm_fire && lvl_en_q) irq_level <= 1'b1;
      else if (irq_clr)           irq_level <= 1'b0;
    end
  end

  always_comb begin
    ctrl_word                      = '0;
    ctrl_word[CB_RUN]              = run_q;
    ctrl_word[CB_UP]               = up_q;
    ctrl_word[CB_AUTO]             = auto_q;
    ctrl_word[CB_ARM]              = arm_q;
    ctrl_word[CB_LVL]              = lvl_en_q;
    ctrl_word[CB_EDGE]             = edge_en_q;
    ctrl_word[CB_DIV_LSB +: DIV_W] = div_q;
    case (addr)
      A_CTRL:    rd_next = ctrl_word;
      A_SNAP_LO: rd_next = snap_q[DATA_W-1:0];
      A_SNAP_HI: rd_next = snap_q[CNT_W-1:DATA_W];
      A_CMP_LO:  rd_next = cmp_q[DATA_W-1:0];
      A_CMP_HI:  rd_next = cmp_q[CNT_W-1:DATA_W];
      A_PRE_LO:  rd_next = pre_q[DATA_W-1:0];
      A_PRE_HI:  rd_next = pre_q[CNT_W-1:DATA_W];
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/alarm_timer64_chk.sv
module alarm_timer64_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_level,
  input logic             irq_edge,
  input logic             irq_clr,
  input logic             alarm_fire,
  input logic             arm_q,
  input logic             load_trig,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] pre_q
);
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq_edge |=> !irq_edge);                                        // R8
  AST_EDGE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq_edge |-> $past(alarm_fire));                                // R8
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq_level && !irq_clr) |=> irq_level);                         // R7
  AST_ARM_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    alarm_fire |=> !arm_q);                                         // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load_trig |=> (count == $past(pre_q)));                         // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_level && !irq_edge));                             // R10
endmodule

bind alarm_timer64 alarm_timer64_chk #(.CNT_W(2 * DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_level  (irq_level),
  .irq_edge   (irq_edge),
  .irq_clr    (irq_clr),
  .alarm_fire (alarm_fire),
  .arm_q      (arm_q),
  .load_trig  (wr_load_trig),
  .count      (count),
  .pre_q      (pre_q)
);

// File: tb/alarm_timer64_test.sv
module alarm_timer64_test;
  import alarm_timer64_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wr_data = 32'd0;
  logic        irq_clr = 1'b0;
  logic [31:0] rd_data;
  logic        irq_level, irq_edge;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;

  always #2 clk = ~clk;

  alarm_timer64 uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .irq_clr(irq_clr), .rd_data(rd_data), .irq_level(irq_level), .irq_edge(irq_edge)
  );

  // behavioural reference
  logic [63:0] m_cnt, m_cmp, m_pre, m_snap;
  logic        m_run, m_up, m_auto, m_arm, m_lvl_en, m_edge_en;
  int          m_div, m_phase;
  logic [31:0] m_rd;
  logic        m_lvl, m_edge;
  logic [3:0]  m_last_addr;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cmp = 0; m_pre = 0; m_snap = 0;
      m_run = 0; m_up = 0; m_auto = 0; m_arm = 0; m_lvl_en = 0; m_edge_en = 0;
      m_div = 0; m_phase = 0; m_rd = 0; m_lvl = 0; m_edge = 0; m_last_addr = 0;
    end else begin
      int n;
      logic step, hit;
      logic [63:0] nxt_cnt;
      logic [31:0] rd_new;
      n    = (m_div < 2) ? 2 : m_div;
      step = m_run && (m_phase >= n - 1);
      hit  = m_arm && (m_cnt == m_cmp);
      case (addr)
        A_CTRL:    rd_new = {16'(m_div), 10'd0, m_edge_en, m_lvl_en, m_arm, m_auto, m_up, m_run};
        A_SNAP_LO: rd_new = m_snap[31:0];
        A_SNAP_HI: rd_new = m_snap[63:32];
        A_CMP_LO:  rd_new = m_cmp[31:0];
        A_CMP_HI:  rd_new = m_cmp[63:32];
        A_PRE_LO:  rd_new = m_pre[31:0];
        A_PRE_HI:  rd_new = m_pre[63:32];
        default:   rd_new = 0;
      endcase
      nxt_cnt = m_cnt;
      if (wr_en && addr == A_LOAD_TRIG) nxt_cnt = m_pre;
      else if (hit && m_auto)           nxt_cnt = m_pre;
      else if (step)                    nxt_cnt = m_up ? m_cnt + 1 : m_cnt - 1;
      if (wr_en && addr == A_SNAP_TRIG) m_snap = m_cnt;
      m_edge = hit && m_edge_en;
      if (hit && m_lvl_en) m_lvl = 1;
      else if (irq_clr)    m_lvl = 0;
      if (!m_run || step) m_phase = 0; else m_phase = m_phase + 1;
      if (hit) m_arm = 0;
      else if (wr_en && addr == A_CTRL) m_arm = wr_data[3];
      if (wr_en) begin
        case (addr)
          A_CTRL: begin
            m_run = wr_data[0]; m_up = wr_data[1]; m_auto = wr_data[2];
            m_lvl_en = wr_data[4]; m_edge_en = wr_data[5]; m_div = int'(wr_data[31:16]);
          end
          A_CMP_LO: m_cmp[31:0]  = wr_data;
          A_CMP_HI: m_cmp[63:32] = wr_data;
          A_PRE_LO: m_pre[31:0]  = wr_data;
          A_PRE_HI: m_pre[63:32] = wr_data;
          default: ;
        endcase
      end
      m_cnt = nxt_cnt;
      m_rd = rd_new;
      m_last_addr = addr;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      chk((m_last_addr == A_SNAP_LO || m_last_addr == A_SNAP_HI) ? "R3 rd_data" : "R11 rd_data",
          64'(rd_data), 64'(m_rd));
      chk("R7 irq_level", 64'(irq_level), 64'(m_lvl));
      chk("R8 irq_edge", 64'(irq_edge), 64'(m_edge));
      if (irq_edge) edges++;
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic look(logic [3:0] a, string tag, logic [31:0] exp);
    addr = a;
    @(negedge clk);
    chk(tag, 64'(rd_data), 64'(exp));
  endtask

  function automatic logic [31:0] ctl(int div, bit edge_en, bit lvl, bit arm, bit auto_r, bit up, bit run);
    return {16'(div), 10'd0, edge_en, lvl, arm, auto_r, up, run};
  endfunction

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] s1;
    int e0;
    repeat (4) @(negedge clk);
    rst = 0;
    // R10 reset state
    look(A_CTRL, "R10 ctrl after reset", 32'd0);
    look(A_SNAP_HI, "R10 snapshot after reset", 32'd0);
    chk("R10 irq_level after reset", 64'(irq_level), 64'd0);

    // R1 divider 0 behaves as 2
    wr(A_CTRL, ctl(0, 0, 0, 0, 0, 1, 1));
    idle(20);
    wr(A_SNAP_TRIG, 0);
    look(A_SNAP_LO, "R1 div0 count", m_snap[31:0]);
    wr(A_CTRL, ctl(1, 0, 0, 0, 0, 1, 1));
    idle(11);
    wr(A_SNAP_TRIG, 0);
    look(A_SNAP_LO, "R1 div1 count", m_snap[31:0]);
    wr(A_CTRL, ctl(7, 0, 0, 0, 0, 1, 1));
    idle(40);
    wr(A_SNAP_TRIG, 0);
    look(A_SNAP_LO, "R1 div7 count", m_snap[31:0]);
    // R1 stop holds; R3 snapshot stays put
    wr(A_CTRL, ctl(7, 0, 0, 0, 0, 1, 0));
    wr(A_SNAP_TRIG, 0);
    look(A_SNAP_LO, "R3 capture", m_snap[31:0]);
    s1 = rd_data;
    idle(15);
    look(A_SNAP_LO, "R3 snapshot unchanged", s1);
    wr(A_SNAP_TRIG, 0);
    look(A_SNAP_LO, "R1 stopped count holds", s1);

    // R4 preset writes alone do nothing
    wr(A_PRE_LO, 32'hDEAD_0000);
    wr(A_PRE_HI, 32'h0000_BEEF);
    wr(A_SNAP_TRIG, 0);
    look(A_SNAP_HI, "R4 no load without trigger", 32'd0);
    look(A_PRE_HI, "R11 preset readback", 32'h0000_BEEF);
    wr(A_LOAD_TRIG, 0);
    wr(A_SNAP_TRIG, 0);
    look(A_SNAP_HI, "R4 load on trigger", 32'h0000_BEEF);

    // R2 down through zero
    wr(A_PRE_LO, 0); wr(A_PRE_HI, 0); wr(A_LOAD_TRIG, 0);
    wr(A_CTRL, ctl(0, 0, 0, 0, 0, 0, 1));
    idle(10);
    wr(A_SNAP_TRIG, 0);
    look(A_SNAP_HI, "R2 borrow into high word", 32'hFFFF_FFFF);
    // R2 up across 32-bit boundary
    wr(A_CTRL, ctl(2, 0, 0, 0, 0, 1, 0));
    wr(A_PRE_LO, 32'hFFFF_FFF0); wr(A_LOAD_TRIG, 0);
    wr(A_CTRL, ctl(2, 0, 0, 0, 0, 1, 1));
    idle(60);
    wr(A_SNAP_TRIG, 0);
    look(A_SNAP_HI, "R2 carry into high word", 32'd1);
    look(A_SNAP_LO, "R2 low word after carry", m_snap[31:0]);

    // R9 load trigger against a step, both phases
    wr(A_PRE_LO, 32'h0000_1234); wr(A_PRE_HI, 32'h0000_0005);
    wr(A_LOAD_TRIG, 0);
    wr(A_SNAP_TRIG, 0);
    look(A_SNAP_LO, "R9 load phase a", 32'h0000_1234);
    idle(1);
    wr(A_LOAD_TRIG, 0);
    wr(A_SNAP_TRIG, 0);
    look(A_SNAP_LO, "R9 load phase b", 32'h0000_1234);

    // R5/R7/R8 alarm without reload
    wr(A_PRE_LO, 100); wr(A_PRE_HI, 0); wr(A_LOAD_TRIG, 0);
    wr(A_CMP_LO, 110); wr(A_CMP_HI, 0);
    e0 = edges;
    wr(A_CTRL, ctl(2, 1, 1, 1, 0, 1, 1));
    idle(40);
    chk("R7 level raised", 64'(irq_level), 64'd1);
    chk("R8 one edge pulse", 64'(edges - e0), 64'd1);
    look(A_CTRL, "R5 arm cleared", ctl(2, 1, 1, 0, 0, 1, 1));
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk("R7 level cleared", 64'(irq_level), 64'd0);

    // R6 auto-reload
    wr(A_CTRL, ctl(2, 0, 0, 0, 0, 1, 0));
    wr(A_PRE_LO, 32'd0); wr(A_PRE_HI, 32'd1); wr(A_LOAD_TRIG, 0);
    wr(A_CMP_LO, 32'd3); wr(A_CMP_HI, 32'd1);
    e0 = edges;
    wr(A_CTRL, ctl(2, 1, 0, 1, 1, 1, 1));
    idle(30);
    wr(A_SNAP_TRIG, 0);
    look(A_SNAP_HI, "R6 reloaded high word", 32'd1);
    look(A_SNAP_LO, "R6 reloaded low word", m_snap[31:0]);
    chk("R6 single alarm after reload", 64'(edges - e0), 64'd1);
    chk("R7 level off when disabled", 64'(irq_level), 64'd0);

    // R11 unmapped address
    look(4'd12, "R11 unmapped reads zero", 32'd0);
    look(A_CMP_HI, "R11 alarm readback", 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule